// File: doc/BRIEF.md
# Timed Traffic Signal Controller

This block runs a single road signal through a fixed cycle of three lamps: go, caution and stop. A one-second enable pulse from an external divider sets the pace. Alongside the lamps it produces a countdown for a two-digit seven-segment display and a one-bit picture selector for an 8x8 dot-matrix panel.

The countdown runs as one span across the go and caution phases. A separate, shorter countdown covers the end of the stop phase, and the digits are blank for the start of that phase. The seven-segment decoder, the dot-matrix row scanner, the bitmaps and the tick divider all sit outside this block. All state changes on the clock edge, and only when the tick is high. The outputs follow the state through combinational logic, so each one is valid just after the edge that updated it.

Top module: `traffic_signal_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block in the start of the go phase. After that edge `lamp_green`=1, `digit_tens`=1, `digit_units`=3 and `pic_sel`=1. These values hold while reset stays high, whatever `tick` does.
- R2: Exactly one of `lamp_green`, `lamp_yellow` and `lamp_red` is 1 in every cycle after reset.
- R3: State and every output change only at a clock edge where `tick` is 1. A cycle with `tick`=0 leaves all outputs unchanged.
- R4: The phases run go for 10 ticks, then caution for 3 ticks, then stop for 10 ticks, then back to go, repeating.
- R5: Across the go and caution phases the displayed value starts at 13 and drops by one on each tick. It runs without a break across the go-to-caution change and reaches 1 on the last caution tick.
- R6: During the first 3 ticks of the stop phase both digits read 4'hF (blank). For the last 7 ticks they show 7 down to 1.
- R7: `pic_sel`=0 selects the first picture and `pic_sel`=1 the second. `pic_sel` is 0 during go and caution, and 1 during stop. After reset it stays 1 until the first tick, which switches it to 0.
- R8: A value that is not blank is shown in BCD. `digit_tens` holds the tens (0 or 1) and `digit_units` the units (0 to 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second enable pulse, one clock wide |
| lamp_green | output | 1 | Go lamp enable |
| lamp_yellow | output | 1 | Caution lamp enable |
| lamp_red | output | 1 | Stop lamp enable |
| digit_tens | output | 4 | Tens BCD digit, 4'hF when blank |
| digit_units | output | 4 | Units BCD digit, 4'hF when blank |
| pic_sel | output | 1 | Dot-matrix picture select: 0 first, 1 second |

## Verification
Every result of this block is due one register stage after its stimulus. The edge that samples a high `tick` or `rst` updates the phase, the elapsed-second count and the start flag. The lamps, digits and picture select then follow through combinational logic before the next edge. The bench drives `tick` and `rst` on the falling edge and samples a quarter period after the following rising edge, so each expected value is compared in the cycle that edge produced. Cycles with `tick` held low are sampled the same way, to show that the outputs did not move.

// File: rtl/traffic_pkg.sv
package traffic_pkg;

   typedef enum logic [1:0] {
      PH_GO      = 2'd0,
      PH_CAUTION = 2'd1,
      PH_STOP    = 2'd2
   } phase_e;

   localparam logic [3:0] BLANK_NIB = 4'hF;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned width_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/tl_phase_seq.sv
module tl_phase_seq
   import traffic_pkg::*;
#(
   parameter int unsigned GREEN_SECS  = 10,
   parameter int unsigned YELLOW_SECS = 3,
   parameter int unsigned RED_SECS    = 10,
   parameter int unsigned CNT_W       = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output phase_e           phase,
   output logic [CNT_W-1:0] elapsed,
   output logic             fresh
);

   localparam logic [CNT_W-1:0] GO_LAST   = CNT_W'(GREEN_SECS - 1);
   localparam logic [CNT_W-1:0] CAU_LAST  = CNT_W'(YELLOW_SECS - 1);
   localparam logic [CNT_W-1:0] STOP_LAST = CNT_W'(RED_SECS - 1);

   logic [CNT_W-1:0] last_sec;
   phase_e           next_phase;

   always_comb begin
      case (phase)
         PH_GO: begin
            last_sec   = GO_LAST;
            next_phase = PH_CAUTION;
         end
         PH_CAUTION: begin
            last_sec   = CAU_LAST;
            next_phase = PH_STOP;
         end
         default: begin
            last_sec   = STOP_LAST;
            next_phase = PH_GO;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= PH_GO;
         elapsed <= '0;
         fresh   <= 1'b1;
      end else if (tick) begin
         fresh <= 1'b0;
         if (elapsed >= last_sec) begin
            elapsed <= '0;
            phase   <= next_phase;
         end else begin
            elapsed <= elapsed + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tl_countdown.sv
module tl_countdown
   import traffic_pkg::*;
#(
   parameter int unsigned GREEN_SECS  = 10,
   parameter int unsigned YELLOW_SECS = 3,
   parameter int unsigned RED_SECS    = 10,
   parameter int unsigned RED_SHOW    = 7,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned VAL_W       = 4
) (
   input  phase_e           phase,
   input  logic [CNT_W-1:0] elapsed,
   output logic [VAL_W-1:0] value,
   output logic             blank
);

   localparam logic [VAL_W-1:0] SPAN_V = VAL_W'(GREEN_SECS + YELLOW_SECS);
   localparam logic [VAL_W-1:0] CAU_V  = VAL_W'(YELLOW_SECS);
   localparam logic [VAL_W-1:0] STOP_V = VAL_W'(RED_SECS);
   localparam logic [VAL_W-1:0] SHOW_V = VAL_W'(RED_SHOW);

   logic [VAL_W-1:0] el_w;
   assign el_w = VAL_W'(elapsed);

   always_comb begin
      blank = 1'b0;
      case (phase)
         PH_GO:      value = SPAN_V - el_w;
         PH_CAUTION: value = CAU_V - el_w;
         default: begin
            value = STOP_V - el_w;
            blank = (value > SHOW_V);
         end
      endcase
   end

endmodule

// File: rtl/tl_bcd_split.sv
module tl_bcd_split
   import traffic_pkg::*;
#(
   parameter int unsigned VAL_W   = 4,
   parameter int unsigned MAX_VAL = 13
) (
   input  logic [VAL_W-1:0] value,
   input  logic             blank,
   output logic [3:0]       tens,
   output logic [3:0]       units
);

   logic [3:0] t_raw;
   logic [3:0] u_raw;

   generate
      if (MAX_VAL > 99) begin : g_range_bad
         $error("tl_bcd_split: MAX_VAL must fit two digits");
      end

      if (MAX_VAL < 10) begin : g_one_digit
         assign t_raw = 4'd0;
         assign u_raw = 4'(value);
      end else begin : g_two_digit
         always_comb begin
            t_raw = 4'd0;
            for (int k = 1; k <= 9; k++) begin
               if (32'(value) >= 32'(10 * k)) t_raw = 4'(k);
            end
            u_raw = 4'(32'(value) - 32'(t_raw) * 10);
         end
      end
   endgenerate

   assign tens  = blank ? BLANK_NIB : t_raw;
   assign units = blank ? BLANK_NIB : u_raw;

endmodule

// File: rtl/traffic_signal_ctrl.sv
module traffic_signal_ctrl
   import traffic_pkg::*;
#(
   parameter int unsigned GREEN_SECS  = 10,
   parameter int unsigned YELLOW_SECS = 3,
   parameter int unsigned RED_SECS    = 10,
   parameter int unsigned RED_SHOW    = 7
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   output logic       lamp_green,
   output logic       lamp_yellow,
   output logic       lamp_red,
   output logic [3:0] digit_tens,
   output logic [3:0] digit_units,
   output logic       pic_sel
);

   localparam int unsigned SPAN_SECS = GREEN_SECS + YELLOW_SECS;
   localparam int unsigned MAX_PHASE = max2(max2(GREEN_SECS, YELLOW_SECS), RED_SECS);
   localparam int unsigned MAX_VAL   = max2(SPAN_SECS, RED_SECS);
   localparam int unsigned CNT_W     = width_for(MAX_PHASE);
   localparam int unsigned VAL_W     = width_for(MAX_VAL);

   generate
      if (GREEN_SECS == 0 || YELLOW_SECS == 0 || RED_SECS == 0) begin : g_bad_len
         $error("traffic_signal_ctrl: every phase needs at least one second");
      end
      if (RED_SHOW == 0 || RED_SHOW > RED_SECS) begin : g_bad_show
         $error("traffic_signal_ctrl: RED_SHOW must lie in 1..RED_SECS");
      end
      if (SPAN_SECS > 99) begin : g_bad_span
         $error("traffic_signal_ctrl: go plus caution must fit two digits");
      end
   endgenerate

   phase_e           phase;
   logic [CNT_W-1:0] elapsed;
   logic             fresh;
   logic [VAL_W-1:0] value;
   logic             blank;

   tl_phase_seq #(
      .GREEN_SECS (GREEN_SECS),
      .YELLOW_SECS(YELLOW_SECS),
      .RED_SECS   (RED_SECS),
      .CNT_W      (CNT_W)
   ) i_seq (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .phase  (phase),
      .elapsed(elapsed),
      .fresh  (fresh)
   );

   tl_countdown #(
      .GREEN_SECS (GREEN_SECS),
      .YELLOW_SECS(YELLOW_SECS),
      .RED_SECS   (RED_SECS),
      .RED_SHOW   (RED_SHOW),
      .CNT_W      (CNT_W),
      .VAL_W      (VAL_W)
   ) i_cd (
      .phase  (phase),
      .elapsed(elapsed),
      .value  (value),
      .blank  (blank)
   );

   tl_bcd_split #(
      .VAL_W  (VAL_W),
      .MAX_VAL(MAX_VAL)
   ) i_bcd (
      .value(value),
      .blank(blank),
      .tens (digit_tens),
      .units(digit_units)
   );

   always_comb begin
      lamp_green  = 1'b0;
      lamp_yellow = 1'b0;
      lamp_red    = 1'b0;
      case (phase)
         PH_GO:      lamp_green  = 1'b1;
         PH_CAUTION: lamp_yellow = 1'b1;
         default:    lamp_red    = 1'b1;
      endcase
   end

   assign pic_sel = fresh | (phase == PH_STOP);

endmodule

// File: rtl/traffic_signal_ctrl_chk.sv
module traffic_signal_ctrl_chk #(
   parameter int unsigned YELLOW_SECS = 3,
   parameter int unsigned RED_SHOW    = 7
) (
   input logic       clk,
   input logic       rst,
   input logic       tick,
   input logic       lamp_green,
   input logic       lamp_yellow,
   input logic       lamp_red,
   input logic [3:0] digit_tens,
   input logic [3:0] digit_units,
   input logic       pic_sel
);

   logic was_run;
   logic was_rst;

   always_ff @(posedge clk) begin
      was_run <= !rst;
      was_rst <= rst;
   end

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
      was_rst |-> (lamp_green && digit_tens == 4'd1 && digit_units == 4'd3 && pic_sel));

   assert_one_lamp_R2: assert property (@(posedge clk) disable iff (rst)
      was_run |-> ($countones({lamp_green, lamp_yellow, lamp_red}) == 1));

   assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
      (was_run && !tick) |=> $stable({lamp_green, lamp_yellow, lamp_red,
                                      digit_tens, digit_units, pic_sel}));

   assert_order_caution_R4: assert property (@(posedge clk) disable iff (rst)
      (was_run && $rose(lamp_yellow)) |-> $past(lamp_green));

   assert_order_stop_R4: assert property (@(posedge clk) disable iff (rst)
      (was_run && $rose(lamp_red)) |-> $past(lamp_yellow));

   assert_caution_count_R5: assert property (@(posedge clk) disable iff (rst)
      (was_run && lamp_yellow) |-> (digit_tens == 4'd0 && digit_units >= 4'd1 &&
                                    32'(digit_units) <= YELLOW_SECS));

   assert_stop_count_R6: assert property (@(posedge clk) disable iff (rst)
      (was_run && lamp_red && digit_units != 4'hF) |->
         (digit_tens == 4'd0 && digit_units >= 4'd1 && 32'(digit_units) <= RED_SHOW));

   assert_stop_picture_R7: assert property (@(posedge clk) disable iff (rst)
      (was_run && lamp_red) |-> pic_sel);

   assert_bcd_digits_R8: assert property (@(posedge clk) disable iff (rst)
      (was_run && digit_units != 4'hF) |-> (digit_units <= 4'd9 && digit_tens <= 4'd9));

endmodule

bind traffic_signal_ctrl traffic_signal_ctrl_chk #(
   .YELLOW_SECS(YELLOW_SECS),
   .RED_SHOW   (RED_SHOW)
) i_chk (
   .clk        (clk),
   .rst        (rst),
   .tick       (tick),
   .lamp_green (lamp_green),
   .lamp_yellow(lamp_yellow),
   .lamp_red   (lamp_red),
   .digit_tens (digit_tens),
   .digit_units(digit_units),
   .pic_sel    (pic_sel)
);

// File: tb/test_traffic_signal_ctrl.sv
module test_traffic_signal_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b0;
   logic       lamp_green, lamp_yellow, lamp_red;
   logic [3:0] digit_tens, digit_units;
   logic       pic_sel;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   traffic_signal_ctrl i_traffic_signal_ctrl (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .lamp_green (lamp_green),
      .lamp_yellow(lamp_yellow),
      .lamp_red   (lamp_red),
      .digit_tens (digit_tens),
      .digit_units(digit_units),
      .pic_sel    (pic_sel)
   );

   // vector: {tick, lamps G/Y/R, tens, units, pic}
   localparam int NV = 27;
   localparam logic [12:0] VEC [NV] = '{
      {1'b1, 3'b100, 4'd1, 4'd2, 1'b0},
      {1'b0, 3'b100, 4'd1, 4'd2, 1'b0},
      {1'b1, 3'b100, 4'd1, 4'd1, 1'b0},
      {1'b1, 3'b100, 4'd1, 4'd0, 1'b0},
      {1'b1, 3'b100, 4'd0, 4'd9, 1'b0},
      {1'b1, 3'b100, 4'd0, 4'd8, 1'b0},
      {1'b1, 3'b100, 4'd0, 4'd7, 1'b0},
      {1'b1, 3'b100, 4'd0, 4'd6, 1'b0},
      {1'b1, 3'b100, 4'd0, 4'd5, 1'b0},
      {1'b1, 3'b100, 4'd0, 4'd4, 1'b0},
      {1'b1, 3'b010, 4'd0, 4'd3, 1'b0},
      {1'b0, 3'b010, 4'd0, 4'd3, 1'b0},
      {1'b1, 3'b010, 4'd0, 4'd2, 1'b0},
      {1'b1, 3'b010, 4'd0, 4'd1, 1'b0},
      {1'b1, 3'b001, 4'hF, 4'hF, 1'b1},
      {1'b1, 3'b001, 4'hF, 4'hF, 1'b1},
      {1'b1, 3'b001, 4'hF, 4'hF, 1'b1},
      {1'b1, 3'b001, 4'd0, 4'd7, 1'b1},
      {1'b0, 3'b001, 4'd0, 4'd7, 1'b1},
      {1'b1, 3'b001, 4'd0, 4'd6, 1'b1},
      {1'b1, 3'b001, 4'd0, 4'd5, 1'b1},
      {1'b1, 3'b001, 4'd0, 4'd4, 1'b1},
      {1'b1, 3'b001, 4'd0, 4'd3, 1'b1},
      {1'b1, 3'b001, 4'd0, 4'd2, 1'b1},
      {1'b1, 3'b001, 4'd0, 4'd1, 1'b1},
      {1'b1, 3'b100, 4'd1, 4'd3, 1'b0},
      {1'b1, 3'b100, 4'd1, 4'd2, 1'b0}
   };

   task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got lamps=%b tens=%h units=%h pic=%b, expected lamps=%b tens=%h units=%h pic=%b",
                  req, got[11:9], got[8:5], got[4:1], got[0],
                  exp[11:9], exp[8:5], exp[4:1], exp[0]);
      end
   endtask

   function automatic logic [11:0] outs();
      return {lamp_green, lamp_yellow, lamp_red, digit_tens, digit_units, pic_sel};
   endfunction

   // drive on falling edge, sample a quarter period after the next rising edge
   task automatic step(input logic t, input logic r);
      @(negedge clk);
      tick = t;
      rst  = r;
      @(posedge clk);
      #5;
   endtask

   localparam logic [11:0] RESET_OUT = {3'b100, 4'd1, 4'd3, 1'b1};

   initial begin
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);
      check("R1 reset state", outs(), RESET_OUT);
      step(1'b1, 1'b1);
      check("R1 reset holds with tick high", outs(), RESET_OUT);

      step(1'b0, 1'b0);
      check("R3/R7 idle after reset keeps second picture", outs(), RESET_OUT);
      step(1'b0, 1'b0);
      check("R3 idle again", outs(), RESET_OUT);

      // R4 R5 R6 R7 R8: full cycle from table
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][12], 1'b0);
         check($sformatf("R4/R5/R6/R7/R8 vector %0d", i), outs(), VEC[i][11:0]);
         checks++;
         if ($countones({lamp_green, lamp_yellow, lamp_red}) != 1) begin
            errors++;
            $display("FAIL R2 lamps=%b expected exactly one set",
                     {lamp_green, lamp_yellow, lamp_red});
         end
      end

      // walk into the stop phase, then reset mid-phase
      for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
      check("R4 stop phase after 8+3+1 ticks from go tick 2", outs(),
            {3'b001, 4'hF, 4'hF, 1'b1});
      step(1'b1, 1'b1);
      check("R1 reset from stop phase", outs(), RESET_OUT);
      step(1'b1, 1'b0);
      check("R7 first tick selects first picture", outs(), {3'b100, 4'd1, 4'd2, 1'b0});
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
      check("R3 long idle stretch", outs(), {3'b100, 4'd1, 4'd2, 1'b0});

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 2000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
      end
      #1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule